// File: doc/BRIEF.md
# Eight-Bit Timer-Counter with Shared Prescaler

This block is an 8-bit up-counter that software can load and read. It counts either instruction cycles, which arrive as a one-clock enable, or edges on an external clock pin. The external pin is synchronised into the system clock first. The user picks which edge counts. When the count wraps from all ones to zero, it raises a sticky overflow flag. That flag drives an interrupt request through a mask bit.

One 8-bit prescaler is shared by the timer and a watchdog tick path. An assignment bit hands the prescaler to one user. The other user then runs undivided. Count pulses pass through a two-stage pipeline before they reach the counter.

A small state machine guards the counter. Its states are ST_RUN, ST_HOLD1, ST_HOLD2 and ST_SLEEP. Its transitions are:
- T_WRITE: any state goes to ST_HOLD1 on a count write. This has the highest priority.
- T_SLEEP: any state goes to ST_SLEEP while the sleep input is high.
- T_STEP1: ST_HOLD1 goes to ST_HOLD2 on an instruction cycle.
- T_STEP2: ST_HOLD2 goes to ST_RUN on an instruction cycle.
- T_WAKE: ST_SLEEP goes to ST_RUN when sleep falls.

The counter accepts pulses only in ST_RUN. This gives the two-instruction-cycle inhibit after a write and the freeze during sleep.

Top module: `tick_timer8`

## Requirements
- R1: After reset the count is 00h, the overflow flag and irq are 0, and the option readback is 3Fh.
- R2: With option bit5=0 (internal source) and bit3=1 (prescaler on the watchdog), the count rises by exactly one per instruction-cycle enable pulse.
- R3: A count write loads wr_data into the count on the next clock. The next two instruction-cycle pulses after the write add nothing. The third pulse counts.
- R4: With bit5=1 and bit4=0, each rising edge of ext_clk adds one and falling edges add nothing.
- R5: With bit5=1 and bit4=1, each falling edge of ext_clk adds one and rising edges add nothing.
- R6: With bit3=0, the timer advances once per 2^(rate+1) source pulses, where rate is bits [2:0]. A count write in this setting also clears the prescaler.
- R7: With bit3=1, wdt_pulse fires once per 2^rate wdt_tick pulses. With bit3=0, wdt_pulse copies wdt_tick.
- R8: A wrap from FFh to 00h by counting sets ovf_flag. The flag stays set until a flag_clr pulse. A set and a clear in the same cycle leave the flag set.
- R9: irq is high exactly when ovf_flag is 1 and option bit6 is 1.
- R10: While sleep is high the count does not change. After sleep falls, the next source pulse counts with no inhibit.
- R11: An option write stores wr_data[6:0], and opt_q reads that value back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cyc_en | input | 1 | One-clock pulse per instruction cycle |
| ext_clk | input | 1 | External count pin, asynchronous |
| sleep | input | 1 | High stops the timer |
| wr_cnt | input | 1 | Load count from wr_data |
| wr_opt | input | 1 | Load options from wr_data[6:0] |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clear the overflow flag |
| wdt_tick | input | 1 | Raw watchdog tick |
| count_q | output | 8 | Current count |
| opt_q | output | 7 | Options: [6] irq mask, [5] source, [4] edge, [3] assignment, [2:0] rate |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt request |
| wdt_pulse | output | 1 | Tick to the watchdog, prescaled or direct |

## Verification
The assertions check several rules on every cycle:
- The count changes only by a load or by a step of one.
- A load lands on the next clock and holds for one more cycle.
- A counted wrap to zero sets the flag, and the flag only leaves by flag_clr.
- Sleep freezes the count.

Other behaviour shows only in the bench's directed scenarios:
- The exact divide ratios on both prescaler users.
- The two-cycle inhibit measured in instruction cycles.
- Which ext_clk edge counts.
- The clearing of the prescaler by a write.
- The irq mask.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int OPT_W  = 7;
    localparam int RATE_W = 3;

    typedef struct packed {
        logic              irq_en;
        logic              src_ext;
        logic              fall_edge;
        logic              to_wdt;
        logic [RATE_W-1:0] rate;
    } opt_t;

    localparam opt_t OPT_RESET = '{irq_en: 1'b0, src_ext: 1'b1, fall_edge: 1'b1,
                                   to_wdt: 1'b1, rate: {RATE_W{1'b1}}};

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD1 = 2'd1,
        ST_HOLD2 = 2'd2,
        ST_SLEEP = 2'd3
    } hold_state_e;

endpackage

// File: rtl/tt_edge_sync.sv
module tt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    // STAGES flops of synchroniser, plus one more holding the previous level
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= pin;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
        end
    end

    logic synced, prev;
    assign synced = sh[STAGES-1];
    assign prev   = sh[STAGES];

    always_comb begin
        if (fall_sel) edge_pulse = prev & ~synced;
        else          edge_pulse = synced & ~prev;
    end

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_pulse,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    output logic              out_pulse
);
    logic [PRE_W-1:0]  cnt;
    logic [RATE_W:0]   k;
    logic [PRE_W-1:0]  mask;

    // timer user divides by 2^(rate+1), watchdog user by 2^rate
    always_comb begin
        if (to_wdt) k = {1'b0, rate};
        else        k = {1'b0, rate} + 1'b1;
        mask      = ~({PRE_W{1'b1}} << k);
        out_pulse = in_pulse && ((cnt & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (in_pulse) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/tt_count_ctrl.sv
module tt_count_ctrl import tick_timer_pkg::*; #(
    parameter int CNT_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             sleep,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             flag_clr,
    input  logic             pulse_in,
    output logic             accept,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    hold_state_e state, state_nx;
    logic [STAGES-1:0] pipe;
    logic inc_ok, inc, wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (wr)         state_nx = ST_HOLD1;   // T_WRITE
        else if (sleep) state_nx = ST_SLEEP;   // T_SLEEP
        else begin
            unique case (state)
                ST_RUN:   state_nx = ST_RUN;
                ST_HOLD1: if (cyc_en) state_nx = ST_HOLD2;  // T_STEP1
                ST_HOLD2: if (cyc_en) state_nx = ST_RUN;    // T_STEP2
                ST_SLEEP: state_nx = ST_RUN;                // T_WAKE
                default:  state_nx = ST_RUN;
            endcase
        end
    end

    always_comb begin
        inc_ok = (state == ST_RUN) && !sleep;
        accept = inc_ok && !wr;
    end

    // count pulse pipeline, flushed by a write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pipe[0] <= 1'b0;
        else if (wr) pipe[0] <= 1'b0;
        else         pipe[0] <= pulse_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_pipe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  pipe[i] <= 1'b0;
            else if (wr) pipe[i] <= 1'b0;
            else         pipe[i] <= pipe[i-1];
        end
    end

    assign inc  = pipe[STAGES-1] && inc_ok && !wr;
    assign wrap = inc && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (wr)  count <= wr_val;
        else if (inc) count <= count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

endmodule

// File: rtl/tick_timer8.sv
module tick_timer8 import tick_timer_pkg::*; #(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int EXT_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ext_clk,
    input  logic             sleep,
    input  logic             wr_cnt,
    input  logic             wr_opt,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    input  logic             wdt_tick,
    output logic [CNT_W-1:0] count_q,
    output logic [OPT_W-1:0] opt_q,
    output logic             ovf_flag,
    output logic             irq,
    output logic             wdt_pulse
);
    opt_t opt_r;
    logic ext_edge, accept, src_raw, src_gated;
    logic pre_in, pre_out, pre_clr, tmr_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      opt_r <= OPT_RESET;
        else if (wr_opt) opt_r <= opt_t'(wr_data[OPT_W-1:0]);
    end

    tt_edge_sync #(.STAGES(EXT_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk),
        .fall_sel(opt_r.fall_edge), .edge_pulse(ext_edge)
    );

    always_comb begin
        src_raw   = opt_r.src_ext ? ext_edge : cyc_en;
        src_gated = src_raw & accept;
        pre_in    = opt_r.to_wdt ? wdt_tick  : src_gated;
        tmr_pulse = opt_r.to_wdt ? src_gated : pre_out;
        wdt_pulse = opt_r.to_wdt ? pre_out   : wdt_tick;
        pre_clr   = wr_cnt & ~opt_r.to_wdt;
    end

    tt_prescaler #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .in_pulse(pre_in),
        .to_wdt(opt_r.to_wdt), .rate(opt_r.rate), .out_pulse(pre_out)
    );

    tt_count_ctrl #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .sleep(sleep),
        .wr(wr_cnt), .wr_val(wr_data), .flag_clr(flag_clr),
        .pulse_in(tmr_pulse), .accept(accept), .count(count_q), .flag(ovf_flag)
    );

    assign irq   = ovf_flag & opt_r.irq_en;
    assign opt_q = opt_r;

endmodule

// File: rtl/tick_timer8_chk.sv
module tick_timer8_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_cnt,
    input logic             sleep,
    input logic             flag_clr,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count_q
);
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CNT_W'(1)));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> count_q == $past(wr_data));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt ##1 !wr_cnt |=> $stable(count_q));

    assert_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == {CNT_W{1'b1}} && !wr_cnt) ##1 (count_q == '0) |-> ovf_flag);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    assert_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> count_q == '0);

    assert_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !wr_cnt) |=> $stable(count_q));

endmodule

bind tick_timer8 tick_timer8_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .sleep(sleep),
    .flag_clr(flag_clr), .ovf_flag(ovf_flag), .wr_data(wr_data), .count_q(count_q)
);

// File: tb/tick_timer8_bench.sv
module tick_timer8_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, ext_clk = 1'b0, sleep = 1'b0;
    logic       wr_cnt = 1'b0, wr_opt = 1'b0, flag_clr = 1'b0, wdt_tick = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] count_q;
    logic [6:0] opt_q;
    logic       ovf_flag, irq, wdt_pulse;

    int checks = 0, errors = 0, wdt_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tick_timer8 u_tick_timer8 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_clk(ext_clk), .sleep(sleep),
        .wr_cnt(wr_cnt), .wr_opt(wr_opt), .wr_data(wr_data), .flag_clr(flag_clr),
        .wdt_tick(wdt_tick), .count_q(count_q), .opt_q(opt_q), .ovf_flag(ovf_flag),
        .irq(irq), .wdt_pulse(wdt_pulse)
    );

    always @(negedge clk) if (wdt_pulse) wdt_seen++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 cyc_en = 1'b1;
            @(posedge clk); #1 cyc_en = 1'b0;
            repeat (3) @(posedge clk);
        end
    endtask

    task automatic wcount(input logic [7:0] v);
        @(posedge clk); #1 wr_cnt = 1'b1; wr_data = v;
        @(posedge clk); #1 wr_cnt = 1'b0;
    endtask

    task automatic wopt(input logic [7:0] v);
        @(posedge clk); #1 wr_opt = 1'b1; wr_data = v;
        @(posedge clk); #1 wr_opt = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 wdt_tick = 1'b1;
            @(posedge clk); #1 wdt_tick = 1'b0;
            @(posedge clk);
        end
    endtask

    task automatic ext(input logic v);
        @(posedge clk); #1 ext_clk = v;
        repeat (5) @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 count", count_q, 8'h00);
        check("R1 flag", ovf_flag, 1'b0);
        check("R1 irq", irq, 1'b0);
        check("R1 opt", opt_q, 7'h3F);
    endtask

    task automatic t_wdt();
        wopt(8'h0A);
        wdt_seen = 0; tick(12); settle();
        check("R7 watchdog 1:4", wdt_seen, 3);
        wopt(8'h02);
        wdt_seen = 0; tick(5); settle();
        check("R7 watchdog direct", wdt_seen, 5);
        check("R11 opt readback", opt_q, 7'h02);
    endtask

    task automatic t_timer();
        wopt(8'h08);
        wcount(8'h10); @(negedge clk);
        check("R3 load", count_q, 8'h10);
        cyc(2); settle();
        check("R3 two cycles inhibited", count_q, 8'h10);
        cyc(1); settle();
        check("R3 third cycle counts", count_q, 8'h11);
        cyc(4); settle();
        check("R2 timer undivided", count_q, 8'h15);
    endtask

    task automatic t_prescale();
        wopt(8'h01);
        wcount(8'h20); cyc(2); cyc(3); settle();
        check("R6 under ratio", count_q, 8'h20);
        wcount(8'h20); cyc(2); cyc(3); settle();
        check("R6 write clears prescaler", count_q, 8'h20);
        cyc(1); settle();
        check("R6 fourth pulse", count_q, 8'h21);
        cyc(4); settle();
        check("R6 1:4 ratio", count_q, 8'h22);
    endtask

    task automatic t_rise();
        wopt(8'h28);
        wcount(8'h40); cyc(2);
        ext(1); ext(0); ext(1); ext(0); ext(1); settle();
        check("R4 rising edges", count_q, 8'h43);
        ext(0); settle();
        check("R4 falling ignored", count_q, 8'h43);
    endtask

    task automatic t_fall();
        wopt(8'h38);
        wcount(8'h50); cyc(2);
        ext(1); ext(0); ext(1); ext(0); ext(1); settle();
        check("R5 falling edges", count_q, 8'h52);
        ext(0); settle();
        check("R5 last fall", count_q, 8'h53);
    endtask

    task automatic t_ovf();
        wopt(8'h48);
        wcount(8'hFE); cyc(2); cyc(1); settle();
        check("R8 no flag at FF", ovf_flag, 1'b0);
        cyc(1); settle();
        check("R8 wrapped", count_q, 8'h00);
        check("R8 flag set", ovf_flag, 1'b1);
        check("R9 irq enabled", irq, 1'b1);
        cyc(1); settle();
        check("R8 flag sticky", ovf_flag, 1'b1);
        @(posedge clk); #1 flag_clr = 1'b1;
        @(posedge clk); #1 flag_clr = 1'b0;
        @(negedge clk);
        check("R8 flag cleared", ovf_flag, 1'b0);
        check("R9 irq cleared", irq, 1'b0);
        wopt(8'h08);
        wcount(8'hFF); cyc(2); cyc(1); settle();
        check("R8 flag again", ovf_flag, 1'b1);
        check("R9 irq masked", irq, 1'b0);
        @(posedge clk); #1 flag_clr = 1'b1;
        @(posedge clk); #1 flag_clr = 1'b0;
    endtask

    task automatic t_sleep();
        wopt(8'h08);
        wcount(8'h30); cyc(2);
        @(posedge clk); #1 sleep = 1'b1;
        cyc(4); settle();
        check("R10 frozen in sleep", count_q, 8'h30);
        @(posedge clk); #1 sleep = 1'b0;
        cyc(1); settle();
        check("R10 resumes after wake", count_q, 8'h31);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_wdt();
        t_timer();
        t_prescale();
        t_rise();
        t_fall();
        t_ovf();
        t_sleep();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule